// File: doc/BRIEF.md
# Paged Data Address Translator

This block turns a 16-bit logical data address into a physical byte address. The top two address bits choose one of four page-pointer registers. The chosen pointer supplies the upper physical bits, and the low fourteen address bits pass through as the offset within the page. A request can also bypass the pointers. It can name a page number directly, or it can name a segment number that sits above the full 16-bit address.

Software loads the pointers through a small write port that takes a 2-bit index. The physical width is a parameter with two supported values, 18 and 24 bits. A word access at an odd address is not translated. It raises a one-cycle trap pulse instead of the valid pulse. Every result appears on registered outputs one clock after the request.

Top module: `paged_xlat`

## Requirements
- R1: After reset, pointer k holds the value k for k = 0..3. An access in mode 00 then gives a physical address equal to the logical address, zero-extended.
- R2: In mode 00, address bits 15:14 select pointer 0..3. The result is {pointer low bits, addr[13:0]}, zero-extended to the physical width. With a 24-bit width the pointer's low 10 bits are used. With an 18-bit width only its low 2 bits are used.
- R3: A pointer write (index `wr_idx`, 10-bit data) takes effect on the next clock. An access in the same cycle as the write still sees the old value.
- R4: In mode 01, the pointers are ignored. The result is {req_page truncated to (width-14) bits, addr[13:0]}.
- R5: In mode 10, the result is {req_seg truncated to (width-16) bits, addr[15:0]}.
- R6: Mode 11 behaves exactly like mode 00.
- R7: A word access (`req_word`=1) at an odd address gives a trap pulse one clock after the request. In that cycle `out_valid` is low, and `out_addr` keeps its previous value.
- R8: A byte access (`req_word`=0) is legal at both odd and even addresses and never traps.
- R9: `out_valid` and `out_trap` are single-cycle pulses, registered one clock after `req_valid`. They are never high together. Without a request both are low and `out_addr` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Pointer write enable |
| wr_idx | input | 2 | Pointer index to write |
| wr_data | input | 10 | Pointer value |
| req_valid | input | 1 | Access request strobe |
| req_addr | input | 16 | Logical address |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_mode | input | 2 | 00 pointer, 01 page override, 10 segment override, 11 as 00 |
| req_page | input | 10 | Page number for mode 01 |
| req_seg | input | 8 | Segment number for mode 10 |
| out_addr | output | PHYS_W | Physical byte address |
| out_valid | output | 1 | Translation done pulse |
| out_trap | output | 1 | Misaligned word access pulse |

## Verification
Every result is due exactly one clock after the request. The address, valid and trap all come from one register stage. Pointer writes become visible to the next request after the writing edge. The bench drives inputs on the falling edge and samples one time unit after the following rising edge, which is the first moment the registered result exists. Expected addresses come from an arithmetic model over a mirror of the pointers that the bench itself wrote. The bench sweeps spread addresses in every mode with several pointer sets.

// File: rtl/paged_xlat_pkg.sv
package paged_xlat_pkg;
  typedef enum logic [1:0] {
    XM_PTR  = 2'b00,
    XM_PAGE = 2'b01,
    XM_SEG  = 2'b10,
    XM_RSVD = 2'b11
  } xlat_mode_e;
endpackage

// File: rtl/paged_xlat_ptrs.sv
module paged_xlat_ptrs #(
  parameter int PTR_W = 10,
  parameter int NPTR  = 4,
  localparam int IDX_W = $clog2(NPTR)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PTR_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [PTR_W-1:0] rd_data
);
  logic [PTR_W-1:0] ptr_q [NPTR];

  generate
    for (genvar k = 0; k < NPTR; k++) begin : g_ptr
      always_ff @(posedge clk) begin
        if (rst)
          ptr_q[k] <= PTR_W'(k);
        else if (wr_en && wr_idx == IDX_W'(k))
          ptr_q[k] <= wr_data;
      end
    end
  endgenerate

  assign rd_data = ptr_q[rd_idx];

  // R3: a write lands in the indexed pointer on the next edge
  a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ptr_q[$past(wr_idx)] == $past(wr_data));
  // R3: pointers change only through the write port
  a_r3_no_stray_change: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(rd_data) || !$stable(rd_idx));
endmodule

// File: rtl/paged_xlat_compose.sv
module paged_xlat_compose
  import paged_xlat_pkg::*;
#(
  parameter int PHYS_W = 24,
  parameter int PTR_W  = 10,
  parameter int SEG_IN = 8,
  localparam int PG_W  = PHYS_W - 14,
  localparam int SG_W  = PHYS_W - 16,
  localparam int PU_W  = (PHYS_W == 24) ? 10 : 2
) (
  input  logic [15:0]       addr,
  input  xlat_mode_e        mode,
  input  logic [PTR_W-1:0]  ptr,
  input  logic [PTR_W-1:0]  page,
  input  logic [SEG_IN-1:0] seg,
  output logic [PHYS_W-1:0] phys
);
  always_comb begin
    phys = '0;
    unique case (mode)
      XM_PAGE: phys = {page[PG_W-1:0], addr[13:0]};
      XM_SEG:  phys = {seg[SG_W-1:0], addr};
      default: begin
        phys[13:0]       = addr[13:0];
        phys[14 +: PU_W] = ptr[PU_W-1:0];
      end
    endcase
  end

  // R2: the offset field always passes through unchanged
  always_comb begin
    a_r2_offset_kept: assert (phys[13:0] == addr[13:0]);
  end
endmodule

// File: rtl/paged_xlat.sv
module paged_xlat
  import paged_xlat_pkg::*;
#(
  parameter int PHYS_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_idx,
  input  logic [9:0]        wr_data,
  input  logic              req_valid,
  input  logic [15:0]       req_addr,
  input  logic              req_word,
  input  logic [1:0]        req_mode,
  input  logic [9:0]        req_page,
  input  logic [7:0]        req_seg,
  output logic [PHYS_W-1:0] out_addr,
  output logic              out_valid,
  output logic              out_trap
);
  localparam int PTR_W = 10;
  localparam int SEG_IN = 8;

  logic [PTR_W-1:0]  sel_ptr;
  logic [PHYS_W-1:0] phys_c;
  logic              misaligned;

  paged_xlat_ptrs #(.PTR_W(PTR_W), .NPTR(4)) u_ptrs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(req_addr[15:14]), .rd_data(sel_ptr)
  );

  paged_xlat_compose #(.PHYS_W(PHYS_W), .PTR_W(PTR_W), .SEG_IN(SEG_IN)) u_comp (
    .addr(req_addr), .mode(xlat_mode_e'(req_mode)), .ptr(sel_ptr),
    .page(req_page), .seg(req_seg), .phys(phys_c)
  );

  assign misaligned = req_word & req_addr[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_addr  <= '0;
      out_valid <= 1'b0;
      out_trap  <= 1'b0;
    end else begin
      out_valid <= req_valid & ~misaligned;
      out_trap  <= req_valid & misaligned;
      if (req_valid && !misaligned)
        out_addr <= phys_c;
    end
  end

  // R9: strobes are exclusive
  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && out_trap));
  // R9: a strobe needs a request one cycle earlier
  a_r9_needs_req: assert property (@(posedge clk) disable iff (rst)
    (out_valid || out_trap) |-> $past(req_valid));
  // R7: trap comes only from an odd word access
  a_r7_trap_cause: assert property (@(posedge clk) disable iff (rst)
    out_trap |-> $past(req_word && req_addr[0]));
  // R7: address output holds across a trap
  a_r7_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !$past(rst)) |-> $stable(out_addr));
  // R8: byte requests always complete
  a_r8_byte_ok: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_word) |=> out_valid);
endmodule

// File: tb/test_paged_xlat.sv
module test_paged_xlat;
  localparam int PW = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_idx = '0;
  logic [9:0] wr_data = '0;
  logic req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic req_word = 1'b0;
  logic [1:0] req_mode = '0;
  logic [9:0] req_page = '0;
  logic [7:0] req_seg = '0;
  logic [PW-1:0] out_addr;
  logic out_valid, out_trap;

  int total = 0;
  int bad = 0;
  int mirror [4];
  bit done = 1'b0;

  always #2 clk = ~clk;

  paged_xlat #(.PHYS_W(PW)) i_paged_xlat (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .req_valid(req_valid), .req_addr(req_addr), .req_word(req_word),
    .req_mode(req_mode), .req_page(req_page), .req_seg(req_seg),
    .out_addr(out_addr), .out_valid(out_valid), .out_trap(out_trap)
  );

  function automatic int model(int a, int m, int pg, int sg);
    int pmask = (PW == 24) ? 32'h3FF : 32'h3;
    int gmask = (1 << (PW - 14)) - 1;
    int smask = (1 << (PW - 16)) - 1;
    int r;
    if (m == 1)      r = ((pg & gmask) << 14) | (a & 32'h3FFF);
    else if (m == 2) r = ((sg & smask) << 16) | (a & 32'hFFFF);
    else             r = ((mirror[(a >> 14) & 3] & pmask) << 14) | (a & 32'h3FFF);
    return r & ((1 << PW) - 1);
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one request; returns after results are settled
  task automatic access(int a, bit w, int m, int pg, int sg);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a[15:0]; req_word = w;
    req_mode = m[1:0]; req_page = pg[9:0]; req_seg = sg[7:0];
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wr_ptr(int k, int v);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = k[1:0]; wr_data = v[9:0];
    @(negedge clk);
    wr_en = 1'b0;
    mirror[k] = v;
  endtask

  task automatic sweep(string req, int m, int pg, int sg);
    for (int a = 16'h0000; a <= 16'hFFFF; a += 16'h0FF6) begin
      access(a & 32'hFFFE, 1'b1, m, pg, sg);
      check(req, out_addr, model(a & 32'hFFFE, m, pg, sg));
      check(req, out_valid, 1);
    end
  endtask

  initial begin
    for (int k = 0; k < 4; k++) mirror[k] = k;
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset valid", out_valid, 0);
    check("R9 reset trap", out_trap, 0);
    check("R9 reset addr", out_addr, 0);
    @(negedge clk); rst = 1'b0;

    // R1 identity after reset
    for (int a = 0; a <= 16'hFFFF; a += 16'h1FFE) begin
      access(a, 1'b0, 0, 0, 0);
      check("R1 identity", out_addr, a);
    end

    // R2 normal translation over several pointer sets
    wr_ptr(0, 10'h3A5); wr_ptr(1, 10'h012); wr_ptr(2, 10'h200); wr_ptr(3, 10'h3FF);
    sweep("R2", 0, 0, 0);
    wr_ptr(0, 10'h155); wr_ptr(1, 10'h2AA); wr_ptr(2, 10'h001); wr_ptr(3, 10'h080);
    sweep("R2", 0, 0, 0);
    // R6 reserved mode acts as pointer mode
    sweep("R6", 3, 10'h3FF, 8'hFF);
    // R4 page override ignores pointers
    sweep("R4", 1, 10'h2C7, 0);
    sweep("R4", 1, 10'h3FF, 8'hFF);
    // R5 segment override
    sweep("R5", 2, 0, 8'hA5);
    sweep("R5", 2, 10'h3FF, 8'hFF);

    // R3 same-cycle write sees old value, next access sees new
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 2'd2; wr_data = 10'h0F0;
    req_valid = 1'b1; req_addr = 16'h8004; req_word = 1'b0; req_mode = 2'b00;
    @(posedge clk); #1;
    wr_en = 1'b0; req_valid = 1'b0;
    check("R3 old value", out_addr, model(16'h8004, 0, 0, 0));
    mirror[2] = 10'h0F0;
    access(16'h8004, 1'b0, 0, 0, 0);
    check("R3 new value", out_addr, (10'h0F0 << 14) | 16'h0004);

    // R7 odd word traps and holds address
    access(16'h4242, 1'b1, 0, 0, 0);
    check("R7 setup", out_addr, model(16'h4242, 0, 0, 0));
    access(16'hC123, 1'b1, 1, 10'h111, 0);
    check("R7 trap", out_trap, 1);
    check("R7 no valid", out_valid, 0);
    check("R7 addr hold", out_addr, model(16'h4242, 0, 0, 0));
    // R9 single-cycle pulse and idle hold
    @(posedge clk); #1;
    check("R9 trap pulse ends", out_trap, 0);
    check("R9 idle valid", out_valid, 0);
    check("R9 idle addr hold", out_addr, model(16'h4242, 0, 0, 0));

    // R8 odd and even bytes are legal
    for (int a = 1; a < 16'hFFFF; a += 16'h3333) begin
      access(a, 1'b0, 2, 0, 8'h5A);
      check("R8 no trap", out_trap, 0);
      check("R8 valid", out_valid, 1);
      check("R8 addr", out_addr, model(a, 2, 0, 8'h5A));
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule